// File: doc/BRIEF.md
# Divide/Square-Root Issue Scheduler

This block is the issue and retirement control of a multi-cycle divide and square-root engine. The engine can hold several operations at once and shares one multiplier-adder among them. A requester presents a start request with a valid bit and an operation-kind bit. The scheduler raises a separate ready output for each kind. That output is high only when the kind's fixed pattern of multiplier use, placed at the current cycle, misses every multiplier cycle that earlier operations have already claimed, and when the in-flight queue still has room. The two ready outputs can therefore switch on and off from one cycle to the next, even when nothing is started.

Every started operation carries a tag and its kind into a four-entry in-order queue. Each entry counts down to its completion cycle, and only the head entry may leave the queue. Results therefore come out strictly in start order, each marked by a strobe for its kind. An operation flagged as a fast-path case, such as an invalid argument, completes in two cycles and claims no multiplier cycles. It still waits behind older work. A four-bit lookahead vector shows which of the current and next three cycles the multiplier is claimed in, so that other logic can use the multiplier in the free cycles.

Top module: `dsqIssueSched`

## Requirements
- R1: A divide starts in a cycle where inValid=1, sqrtOp=0 and readyDiv=1. A square root starts in a cycle where inValid=1, sqrtOp=1 and readySqrt=1. A request made while the ready output of its kind is 0 is ignored and never produces a result.
- R2: readyDiv (readySqrt) is 1 exactly when fewer than four operations are in flight and the kind's usage mask does not overlap the reservation register shifted down by one bit.
- R3: No more than four operations are ever in flight. When four are in flight, both ready outputs are 0.
- R4: Results leave one per cycle at most, strictly in start order. outTag carries the tag of the retiring operation. The strobe is outValidDiv for a divide and outValidSqrt for a square root, never both together.
- R5: A normal divide with nothing older pending raises its strobe in the 19th cycle, counting the start cycle as the first. A normal square root does so in the 27th cycle. An operation that is waiting behind an older one retires in the cycle after that older one retires.
- R6: An operation started with inFast=1 completes in its 2nd cycle. It claims no multiplier cycles, and it still never retires before older operations.
- R7: Mask bit k set means the operation uses the multiplier k+1 cycles after its start cycle. The divide mask sets bits 2,3,4,13,14,15 (24'h00E01C). The square-root mask sets bits 2..9,20,21 (24'h3003FC). On a normal start the mask is ORed into the reservation register, which shifts down one bit each cycle. usage[i] is reservation bit i, so usage[0] shows the current cycle and usage[3] shows three cycles ahead.
- R8: With a lone divide in flight, readyDiv is high again no more than 6 cycles after its start. With a lone square root in flight, readySqrt is high again no more than 10 cycles after its start.
- R9: A synchronous active-high reset empties the queue and clears the reservation register. In the first cycle afterwards both ready outputs are 1, usage is 0 and no strobe is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Start request |
| sqrtOp | input | 1 | Kind of request: 0 divide, 1 square root |
| inFast | input | 1 | Request is a fast-path case (two-cycle completion, no multiplier) |
| inTag | input | TAG_W (4) | Tag carried by the operation |
| readyDiv | output | 1 | A divide may start this cycle |
| readySqrt | output | 1 | A square root may start this cycle |
| usage | output | USE_W (4) | Multiplier claimed now (bit 0) and in the next three cycles |
| outValidDiv | output | 1 | A divide retires this cycle |
| outValidSqrt | output | 1 | A square root retires this cycle |
| outTag | output | TAG_W (4) | Tag of the retiring operation |

## Verification
The hardest state to reach from the ports is a full queue. The multiplier masks space normal operations so far apart that older ones retire before a fifth could be started. The bench therefore starts one long normal divide and follows it with fast-path divides, which claim no multiplier cycles, in each cycle that readyDiv allows. This holds four operations in flight behind a head that has not completed. The bench then checks that both ready outputs drop and that the younger fast-path results queue up behind the divide in order. A cycle-accurate model of the masks and of the queue also checks readiness, usage and every retirement across directed and pseudo-random request streams. These streams include a reset taken while operations are in flight.

// File: rtl/dsqSchedPkg.sv
package dsqSchedPkg;

  // Strobes from the issue control to the operation queue
  typedef struct packed {
    logic push;        // an operation starts this cycle
    logic pushSqrt;    // kind of the starting operation: 1 = square root
    logic pushFast;    // starting operation takes the short fast path
  } issueStrobe_t;

endpackage

// File: rtl/dsqSchedCtrl.sv
module dsqSchedCtrl
  import dsqSchedPkg::*;
#(
  parameter int DEPTH = 4,
  parameter int RES_W = 24,
  parameter int USE_W = 4,
  parameter logic [RES_W-1:0] DIV_MASK  = 24'h00E01C,
  parameter logic [RES_W-1:0] SQRT_MASK = 24'h3003FC
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         inValid,
  input  logic                         sqrtOp,
  input  logic                         inFast,
  input  logic [$clog2(DEPTH+1)-1:0]   inFlight,
  output logic                         readyDiv,
  output logic                         readySqrt,
  output logic [USE_W-1:0]             usage,
  output issueStrobe_t                 strobes
);

  localparam int CNT_W = $clog2(DEPTH+1);

  logic [RES_W-1:0] resv;
  logic [RES_W-1:0] resvShift;
  logic [RES_W-1:0] resvAdd;
  logic             roomLeft;
  logic             divClash;
  logic             sqrtClash;

  // The reservation window seen by an operation starting this cycle
  assign resvShift = resv >> 1;
  assign roomLeft  = inFlight < CNT_W'(DEPTH);
  assign divClash  = |(resvShift & DIV_MASK);
  assign sqrtClash = |(resvShift & SQRT_MASK);

  assign readyDiv  = roomLeft && !divClash;
  assign readySqrt = roomLeft && !sqrtClash;

  always_comb begin
    strobes          = '0;
    strobes.push     = inValid && (sqrtOp ? readySqrt : readyDiv);
    strobes.pushSqrt = sqrtOp;
    strobes.pushFast = inFast;
  end

  // Fast-path operations claim no multiplier cycles
  assign resvAdd = (strobes.push && !inFast) ? (sqrtOp ? SQRT_MASK : DIV_MASK) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      resv <= '0;
    end else begin
      resv <= resvShift | resvAdd;
    end
  end

  assign usage = resv[USE_W-1:0];

endmodule

// File: rtl/dsqOpQueue.sv
module dsqOpQueue
  import dsqSchedPkg::*;
#(
  parameter int DEPTH    = 4,
  parameter int TAG_W    = 4,
  parameter int DIV_LAT  = 19,
  parameter int SQRT_LAT = 27,
  parameter int FAST_LAT = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  issueStrobe_t                 strobes,
  input  logic [TAG_W-1:0]             inTag,
  output logic [$clog2(DEPTH+1)-1:0]   inFlight,
  output logic                         outValidDiv,
  output logic                         outValidSqrt,
  output logic [TAG_W-1:0]             outTag
);

  localparam int CNT_W   = $clog2(DEPTH+1);
  localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LAT_MAX = (DIV_LAT > SQRT_LAT) ? DIV_LAT : SQRT_LAT;
  localparam int REM_W   = $clog2(LAT_MAX);
  // Countdown loaded at start so that zero is reached in cycle LAT of the op
  localparam logic [REM_W-1:0] DIV_LOAD  = REM_W'(DIV_LAT - 2);
  localparam logic [REM_W-1:0] SQRT_LOAD = REM_W'(SQRT_LAT - 2);
  localparam logic [REM_W-1:0] FAST_LOAD = REM_W'(FAST_LAT - 2);

  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [CNT_W-1:0] count;
  logic [DEPTH-1:0] entValid;
  logic [DEPTH-1:0] entSqrt;
  logic [DEPTH-1:0] entDone;
  logic [TAG_W-1:0] entTag [DEPTH];
  logic [REM_W-1:0] entRem [DEPTH];
  logic [REM_W-1:0] loadRem;
  logic             headDone;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    if (strobes.pushFast)      loadRem = FAST_LOAD;
    else if (strobes.pushSqrt) loadRem = SQRT_LOAD;
    else                       loadRem = DIV_LOAD;
  end

  // Per-entry completion flags
  for (genvar e = 0; e < DEPTH; e++) begin : g_done
    assign entDone[e] = entValid[e] && (entRem[e] == '0);
  end

  assign headDone = entDone[rdPtr];

  always_ff @(posedge clk) begin
    if (rst) begin
      entValid <= '0;
      entSqrt  <= '0;
      for (int e = 0; e < DEPTH; e++) begin
        entTag[e] <= '0;
        entRem[e] <= '0;
      end
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (strobes.push && wrPtr == PTR_W'(e)) begin
          entValid[e] <= 1'b1;
          entSqrt[e]  <= strobes.pushSqrt;
          entTag[e]   <= inTag;
          entRem[e]   <= loadRem;
        end else if (headDone && rdPtr == PTR_W'(e)) begin
          entValid[e] <= 1'b0;
        end else if (entValid[e] && entRem[e] != '0) begin
          entRem[e] <= entRem[e] - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobes.push) wrPtr <= nextPtr(wrPtr);
      if (headDone)     rdPtr <= nextPtr(rdPtr);
      count <= count + CNT_W'(strobes.push) - CNT_W'(headDone);
    end
  end

  assign inFlight     = count;
  assign outValidDiv  = headDone && !entSqrt[rdPtr];
  assign outValidSqrt = headDone &&  entSqrt[rdPtr];
  assign outTag       = entTag[rdPtr];

endmodule

// File: rtl/dsqIssueSched.sv
module dsqIssueSched
  import dsqSchedPkg::*;
#(
  parameter int DEPTH    = 4,
  parameter int TAG_W    = 4,
  parameter int RES_W    = 24,
  parameter int USE_W    = 4,
  parameter int DIV_LAT  = 19,
  parameter int SQRT_LAT = 27,
  parameter int FAST_LAT = 2,
  parameter logic [RES_W-1:0] DIV_MASK  = 24'h00E01C,
  parameter logic [RES_W-1:0] SQRT_MASK = 24'h3003FC
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic               sqrtOp,
  input  logic               inFast,
  input  logic [TAG_W-1:0]   inTag,
  output logic               readyDiv,
  output logic               readySqrt,
  output logic [USE_W-1:0]   usage,
  output logic               outValidDiv,
  output logic               outValidSqrt,
  output logic [TAG_W-1:0]   outTag
);

  localparam int CNT_W = $clog2(DEPTH+1);

  issueStrobe_t     strobes;
  logic [CNT_W-1:0] inFlight;

  dsqSchedCtrl #(
    .DEPTH(DEPTH), .RES_W(RES_W), .USE_W(USE_W),
    .DIV_MASK(DIV_MASK), .SQRT_MASK(SQRT_MASK)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .inValid(inValid), .sqrtOp(sqrtOp), .inFast(inFast),
    .inFlight(inFlight),
    .readyDiv(readyDiv), .readySqrt(readySqrt),
    .usage(usage), .strobes(strobes)
  );

  dsqOpQueue #(
    .DEPTH(DEPTH), .TAG_W(TAG_W),
    .DIV_LAT(DIV_LAT), .SQRT_LAT(SQRT_LAT), .FAST_LAT(FAST_LAT)
  ) u_queue (
    .clk(clk), .rst(rst),
    .strobes(strobes), .inTag(inTag),
    .inFlight(inFlight),
    .outValidDiv(outValidDiv), .outValidSqrt(outValidSqrt),
    .outTag(outTag)
  );

endmodule

// File: rtl/dsqIssueSched_chk.sv
module dsqIssueSched_chk #(
  parameter int DEPTH = 4,
  parameter int USE_W = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       inValid,
  input logic                       sqrtOp,
  input logic                       startPulse,
  input logic                       readyDiv,
  input logic                       readySqrt,
  input logic [USE_W-1:0]           usage,
  input logic                       outValidDiv,
  input logic                       outValidSqrt,
  input logic [$clog2(DEPTH+1)-1:0] inFlight
);

  // R1: a start only happens on a request of a ready kind
  p_start_ready_r1: assert property (@(posedge clk) disable iff (rst)
    startPulse |-> (inValid && (sqrtOp ? readySqrt : readyDiv)));

  // R3: occupancy bound
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    int'(inFlight) <= DEPTH);

  // R3: a full queue blocks both kinds
  p_full_blocks_r3: assert property (@(posedge clk) disable iff (rst)
    (int'(inFlight) == DEPTH) |-> (!readyDiv && !readySqrt));

  // R4: never two strobes in one cycle
  p_single_done_r4: assert property (@(posedge clk) disable iff (rst)
    !(outValidDiv && outValidSqrt));

  // R4: a retirement needs an occupied queue
  p_done_nonempty_r4: assert property (@(posedge clk) disable iff (rst)
    (outValidDiv || outValidSqrt) |-> (inFlight != '0));

  // R4: occupancy follows starts and retirements
  p_count_track_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> int'(inFlight) == int'($past(inFlight)) + int'($past(startPulse))
                               - int'($past(outValidDiv || outValidSqrt)));

  // R7: a claimed future multiplier cycle is never dropped as time advances
  p_usage_keep_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(usage[USE_W-1:1]) & ~usage[USE_W-2:0]) == '0));

  // R9: clean state right after reset
  p_reset_state_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (readyDiv && readySqrt && usage == '0 && inFlight == '0
                    && !outValidDiv && !outValidSqrt));

endmodule

bind dsqIssueSched dsqIssueSched_chk #(.DEPTH(DEPTH), .USE_W(USE_W)) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .sqrtOp(sqrtOp),
  .startPulse(strobes.push), .readyDiv(readyDiv), .readySqrt(readySqrt),
  .usage(usage), .outValidDiv(outValidDiv), .outValidSqrt(outValidSqrt),
  .inFlight(inFlight)
);

// File: tb/dsqIssueSched_tb.sv
module dsqIssueSched_tb;

  localparam logic [23:0] M_DIV  = 24'h00E01C;
  localparam logic [23:0] M_SQRT = 24'h3003FC;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       inValid = 1'b0;
  logic       sqrtOp = 1'b0;
  logic       inFast = 1'b0;
  logic [3:0] inTag = '0;
  logic       readyDiv, readySqrt, outValidDiv, outValidSqrt;
  logic [3:0] usage, outTag;

  dsqIssueSched u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .sqrtOp(sqrtOp), .inFast(inFast),
    .inTag(inTag), .readyDiv(readyDiv), .readySqrt(readySqrt), .usage(usage),
    .outValidDiv(outValidDiv), .outValidSqrt(outValidSqrt), .outTag(outTag)
  );

  always #4 clk = ~clk;  // 125 MHz

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 0;
  int wdCycles = 0;

  // Reference model
  logic [23:0] mResv;
  int mHead, mTail, cyc;
  logic [3:0] mTag [16];
  bit         mSqrt [16];
  int         mDue  [16];
  // Retirement log
  logic [3:0] retTag [256];
  int         retCyc [256];
  int         retCnt = 0;
  int         lastDivCyc, lastSqrtCyc;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    wdCycles++;
    if (wdCycles > 20000 && !finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog run hung actual=%0d expected=%0d", wdCycles, 20000);
      summary();
    end
  end

  function automatic bit mReady(input bit sq);
    logic [23:0] m;
    m = sq ? M_SQRT : M_DIV;
    return ((mTail - mHead) < 4) && (((mResv >> 1) & m) == '0);
  endfunction

  // One cycle: called at a falling edge, returns at the next falling edge
  task automatic step(input bit v, input bit op, input bit fast,
                      input logic [3:0] tg, output bit started);
    bit pop, expD, expS;
    pop  = (mTail != mHead) && (cyc >= mDue[mHead % 16]);
    expD = pop && !mSqrt[mHead % 16];
    expS = pop &&  mSqrt[mHead % 16];
    chk(readyDiv === mReady(1'b0), "R2", "readyDiv", int'(readyDiv), int'(mReady(1'b0)));
    chk(readySqrt === mReady(1'b1), "R2", "readySqrt", int'(readySqrt), int'(mReady(1'b1)));
    chk(usage === mResv[3:0], "R7", "usage", int'(usage), int'(mResv[3:0]));
    chk(outValidDiv === expD, "R4", "outValidDiv", int'(outValidDiv), int'(expD));
    chk(outValidSqrt === expS, "R4", "outValidSqrt", int'(outValidSqrt), int'(expS));
    if (pop)
      chk(outTag === mTag[mHead % 16], "R4", "outTag", int'(outTag), int'(mTag[mHead % 16]));
    if (outValidDiv || outValidSqrt) begin
      retTag[retCnt % 256] = outTag;
      retCyc[retCnt % 256] = cyc;
      retCnt++;
      if (outValidDiv) lastDivCyc = cyc;
      if (outValidSqrt) lastSqrtCyc = cyc;
    end
    started = v && mReady(op);
    inValid = v; sqrtOp = op; inFast = fast; inTag = tg;
    @(posedge clk);
    if (pop) mHead++;
    if (started) begin
      mTag[mTail % 16]  = tg;
      mSqrt[mTail % 16] = op;
      mDue[mTail % 16]  = cyc + (fast ? 1 : (op ? 26 : 18));
      mTail++;
    end
    mResv = (mResv >> 1) | ((started && !fast) ? (op ? M_SQRT : M_DIV) : 24'h0);
    cyc++;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic idle(input int n);
    bit s;
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 4'h0, s);
  endtask

  task automatic drain();
    bit s;
    for (int i = 0; i < 60 && ((mTail != mHead) || (mResv != '0)); i++)
      step(1'b0, 1'b0, 1'b0, 4'h0, s);
  endtask

  task automatic doReset();
    rst = 1'b1;
    inValid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    mResv = '0; mHead = 0; mTail = 0; cyc = 0;
  endtask

  task automatic t_reset();
    doReset();
    chk(readyDiv === 1'b1 && readySqrt === 1'b1, "R9", "ready after reset",
        int'({readyDiv, readySqrt}), 3);
    chk(usage === 4'h0, "R9", "usage after reset", int'(usage), 0);
    chk(!outValidDiv && !outValidSqrt, "R9", "no strobe after reset",
        int'({outValidDiv, outValidSqrt}), 0);
  endtask

  task automatic t_single_div();
    bit s;
    int c0;
    c0 = cyc;
    step(1'b1, 1'b0, 1'b0, 4'h1, s);
    chk(s, "R1", "divide starts when ready", int'(s), 1);
    chk(usage === 4'b1100, "R7", "usage one cycle after divide", int'(usage), 12);
    step(1'b0, 1'b0, 1'b0, 4'h0, s);
    chk(usage === 4'b1110, "R7", "usage two cycles after divide", int'(usage), 14);
    drain();
    chk(lastDivCyc - c0 == 18, "R5", "divide latency", lastDivCyc - c0 + 1, 19);
  endtask

  task automatic t_single_sqrt();
    bit s;
    int c0;
    c0 = cyc;
    step(1'b1, 1'b1, 1'b0, 4'h2, s);
    chk(s, "R1", "square root starts when ready", int'(s), 1);
    drain();
    chk(lastSqrtCyc - c0 == 26, "R5", "square root latency", lastSqrtCyc - c0 + 1, 27);
  endtask

  task automatic t_fast();
    bit s;
    int c0;
    c0 = cyc;
    step(1'b1, 1'b1, 1'b1, 4'h3, s);
    chk(usage === 4'h0, "R6", "fast op claims no multiplier", int'(usage), 0);
    chk(outValidSqrt === 1'b1 && outTag === 4'h3, "R6", "fast op done in 2nd cycle",
        int'(outValidSqrt), 1);
    drain();
    chk(lastSqrtCyc - c0 == 1, "R6", "fast latency", lastSqrtCyc - c0 + 1, 2);
  endtask

  task automatic t_spacing();
    bit s;
    int c0, gap;
    c0 = cyc;
    step(1'b1, 1'b0, 1'b0, 4'h4, s);
    gap = 0;
    s = 0;
    for (int i = 1; i < 20 && !s; i++) begin
      step(1'b1, 1'b0, 1'b0, 4'h5, s);
      gap = i;
    end
    chk(s && gap <= 6, "R8", "divide-to-divide gap", gap, 6);
    drain();
    step(1'b1, 1'b1, 1'b0, 4'h6, s);
    gap = 0;
    s = 0;
    for (int i = 1; i < 30 && !s; i++) begin
      step(1'b1, 1'b1, 1'b0, 4'h7, s);
      gap = i;
    end
    chk(s && gap <= 10, "R8", "sqrt-to-sqrt gap", gap, 10);
    drain();
  endtask

  task automatic t_ignored();
    bit s;
    int r0;
    bit seen;
    r0 = retCnt;
    step(1'b1, 1'b0, 1'b0, 4'h5, s);
    chk(readyDiv === 1'b0, "R1", "divide blocked right after divide", int'(readyDiv), 0);
    step(1'b1, 1'b0, 1'b0, 4'hF, s);
    chk(!s, "R1", "blocked request not started", int'(s), 0);
    drain();
    seen = 0;
    for (int i = r0; i < retCnt; i++) if (retTag[i % 256] == 4'hF) seen = 1;
    chk(!seen, "R1", "ignored request produced no result", int'(seen), 0);
    chk(retCnt - r0 == 1, "R1", "result count after ignored request", retCnt - r0, 1);
  endtask

  task automatic t_full();
    bit s;
    int n, r0;
    r0 = retCnt;
    step(1'b1, 1'b0, 1'b0, 4'h1, s);
    n = 0;
    for (int i = 0; i < 20 && n < 3; i++) begin
      step(1'b1, 1'b0, 1'b1, 4'(2 + n), s);
      if (s) n++;
    end
    chk(n == 3, "R3", "fast ops queued behind divide", n, 3);
    chk(readyDiv === 1'b0 && readySqrt === 1'b0, "R3", "both ready low when full",
        int'({readyDiv, readySqrt}), 0);
    step(1'b1, 1'b1, 1'b1, 4'hE, s);
    chk(!s, "R3", "no fifth operation", int'(s), 0);
    drain();
    chk(retCnt - r0 == 4, "R4", "retire count", retCnt - r0, 4);
    for (int i = 0; i < 4; i++)
      chk(retTag[(r0 + i) % 256] == 4'(1 + i), "R6", "fast ops keep order",
          int'(retTag[(r0 + i) % 256]), 1 + i);
    for (int i = 1; i < 4; i++)
      chk(retCyc[(r0 + i) % 256] == retCyc[(r0 + i - 1) % 256] + 1, "R5",
          "waiting op retires next cycle", retCyc[(r0 + i) % 256] - retCyc[(r0 + i - 1) % 256], 1);
  endtask

  task automatic t_mix();
    bit s;
    logic [15:0] lf;
    int f0;
    lf = 16'hACE1;
    f0 = nFail;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[0] | lf[5], lf[3], (lf[7:4] == 4'h9), 4'(i), s);
    end
    drain();
    chk(nFail == f0, "R2", "mixed stream matches model", nFail - f0, 0);
  endtask

  task automatic t_reset_busy();
    bit s;
    step(1'b1, 1'b1, 1'b0, 4'h8, s);
    step(1'b1, 1'b0, 1'b1, 4'h9, s);
    idle(3);
    t_reset();
    idle(30);
    chk(mTail == mHead, "R9", "queue empty after reset", mTail - mHead, 0);
  endtask

  initial begin
    lastDivCyc = 0;
    lastSqrtCyc = 0;
    @(negedge clk);
    t_reset();
    t_single_div();
    t_single_sqrt();
    t_fast();
    t_spacing();
    t_ignored();
    t_full();
    t_mix();
    t_reset_busy();
    summary();
  end

endmodule